// File: doc/BRIEF.md
# Latched-Address External Bus Write Sequencer

This block carries out single write transfers to an external byte-wide peripheral bus whose address is wider than its pins. The low twelve address bits go out on a direct address port. The full 28-bit address is also sent over the 8-bit data port as three byte slices, from most to least significant. Each slice is captured by its own external latch strobe, and the strobes are spaced a fixed number of clocks apart. Once the address is out, the write byte is driven and one of four active-low chip selects is asserted. In the alternative mode a single enable line is asserted instead. A write qualifier then follows, and the block inserts wait states until the peripheral raises its ready input.

The host presents an address, a data byte and a mode bit, and pulses a start signal for one clock. The chip select comes from four base/mask windows, and the lowest-index window that matches wins. A request that falls in no window starts no bus activity and raises an error pulse instead. The host sees completion as a one-clock done pulse. The strobes drop one clock after the chip select releases, and the block then returns to idle.

Top module: `lat_wr_seq`

## Requirements
- R1: After reset, and whenever idle, the outputs are quiet: `xa` and `xd` are zero, `stb` is 000, `cs_n` is all ones, and `en`, `wr`, `done` and `err` are low.
- R2: A request accepted at clock edge E0 (`req_valid` high while idle) drives `xa` = addr[11:0] and `xd` = addr[27:20] from E0. `stb[2]` rises at E2.
- R3: `xd` changes to addr[19:12] at E4 and `stb[1]` rises at E6. `xd` changes to addr[11:4] at E8 and `stb[0]` rises at E10. Once a strobe is raised it stays high until the release.
- R4: `xd` carries the write data byte from E12 until the strobe release.
- R5: At E13, if `req_mode` was 0 at acceptance, the selected bit of `cs_n` goes low and `en` stays low. If `req_mode` was 1, `en` goes high and `cs_n` stays all ones.
- R6: The selected chip select is the lowest index i for which ((addr XOR base_i) AND mask_i) == 0. base_i and mask_i are bits [28i+27:28i] of `map_base` and `map_mask`.
- R7: `wr` rises at E14. `bus_rdy` is sampled from E15 on. If it is low on W consecutive edges, then at E15+W `wr`, the chip select and `en` release, and `done` is high for exactly that one cycle.
- R8: At E16+W all three strobes fall together, and `xa` and `xd` return to zero.
- R9: `req_valid` is ignored while a transfer is in progress. A pulse mid-transfer changes no output and starts no second transfer.
- R10: A request matching no window drives no strobe, chip select or enable. Instead `err` is high for the one cycle after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start pulse for a write request |
| req_addr | input | 28 | Target address |
| req_data | input | 8 | Write data byte |
| req_mode | input | 1 | 0: chip-select mode, 1: single enable mode |
| map_base | input | 112 | Four 28-bit window bases, window i at [28i+27:28i] |
| map_mask | input | 112 | Four 28-bit window compare masks |
| bus_rdy | input | 1 | Peripheral ready, active high |
| xa | output | 12 | Direct address bits 11:0 |
| xd | output | 8 | Multiplexed address slices, then write data |
| stb | output | 3 | Latch strobes, bit 2 for the highest slice |
| cs_n | output | 4 | Active-low chip selects |
| en | output | 1 | Enable used in place of chip selects in mode 1 |
| wr | output | 1 | Write qualifier |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an unmapped request |

## Verification
The properties assume that `bus_rdy` can stay low for any length of time. They also assume that the window registers stay constant while a transfer runs. The bench changes `map_base` and `map_mask` only at reset. The request fields matter only on the acceptance edge, so the bench may change them at any time. All inputs are driven on falling edges. Wait counts are drawn from a small range so that every ready-sampling edge lands in a checked cycle.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WAIT,
      ST_REL
   } lwb_state_e;
endpackage

// File: rtl/lwb_step_ctr.sv
module lwb_step_ctr #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   output logic [CW-1:0] count
);
   // clear loads 1 so that the value equals the edge index counted from acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= CW'(1);
      else if (run)   count <= count + CW'(1);
   end
endmodule

// File: rtl/lwb_cs_decode.sv
module lwb_cs_decode #(
   parameter int AW  = 28,
   parameter int NCS = 4,
   localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic [AW-1:0]     addr,
   input  logic [NCS*AW-1:0] base,
   input  logic [NCS*AW-1:0] mask,
   output logic              hit,
   output logic [SW-1:0]     sel
);
   logic [NCS-1:0] match;

   for (genvar i = 0; i < NCS; i++) begin : g_win
      assign match[i] = ((addr ^ base[i*AW +: AW]) & mask[i*AW +: AW]) == '0;
   end

   always_comb begin
      sel = '0;
      for (int i = NCS - 1; i >= 0; i--) begin
         if (match[i]) sel = SW'(i);
      end
   end

   assign hit = |match;
endmodule

// File: rtl/lat_wr_seq.sv
module lat_wr_seq
   import lwb_pkg::*;
#(
   parameter int AW  = 28,
   parameter int DW  = 8,
   parameter int DAW = 12,
   parameter int NCS = 4,
   parameter int GAP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_data,
   input  logic              req_mode,
   input  logic [NCS*AW-1:0] map_base,
   input  logic [NCS*AW-1:0] map_mask,
   input  logic              bus_rdy,
   output logic [DAW-1:0]    xa,
   output logic [DW-1:0]     xd,
   output logic [2:0]        stb,
   output logic [NCS-1:0]    cs_n,
   output logic              en,
   output logic              wr,
   output logic              done,
   output logic              err
);
   localparam int SW     = (NCS > 1) ? $clog2(NCS) : 1;
   localparam int E_STB2 = GAP;
   localparam int E_MID  = 2 * GAP;
   localparam int E_STB1 = 3 * GAP;
   localparam int E_LOW  = 4 * GAP;
   localparam int E_STB0 = 5 * GAP;
   localparam int E_DATA = 6 * GAP;
   localparam int E_SEL  = 6 * GAP + 1;
   localparam int E_WR   = 6 * GAP + 2;
   localparam int CW     = $clog2(E_WR + 1) + 1;

   if (AW != DAW + 2 * DW) begin : g_bad_aw
      $error("AW must equal DAW + 2*DW so three slices end at bit DAW-DW");
   end
   if (DAW < DW) begin : g_bad_daw
      $error("DAW must be at least DW");
   end
   if (GAP < 1) begin : g_bad_gap
      $error("GAP must be at least 1");
   end
   if (NCS < 2) begin : g_bad_ncs
      $error("NCS must be at least 2");
   end

   lwb_state_e      state;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   data_q;
   logic            mode_q;
   logic [SW-1:0]   sel_q;
   logic            dec_hit;
   logic [SW-1:0]   dec_sel;
   logic [CW-1:0]   step;
   logic            accept;

   lwb_cs_decode #(.AW(AW), .NCS(NCS)) u_dec (
      .addr (req_addr),
      .base (map_base),
      .mask (map_mask),
      .hit  (dec_hit),
      .sel  (dec_sel)
   );

   assign accept = (state == ST_IDLE) && req_valid && dec_hit;

   lwb_step_ctr #(.CW(CW)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .run   (state == ST_ADDR),
      .count (step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         data_q <= '0;
         mode_q <= 1'b0;
         sel_q  <= '0;
         xa     <= '0;
         xd     <= '0;
         stb    <= '0;
         cs_n   <= '1;
         en     <= 1'b0;
         wr     <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               done <= 1'b0;
               err  <= req_valid && !dec_hit;
               if (accept) begin
                  addr_q <= req_addr;
                  data_q <= req_data;
                  mode_q <= req_mode;
                  sel_q  <= dec_sel;
                  xa     <= req_addr[DAW-1:0];
                  xd     <= req_addr[AW-1 -: DW];
                  state  <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (step == CW'(E_STB2)) stb[2] <= 1'b1;
               if (step == CW'(E_MID))  xd     <= addr_q[AW-1-DW -: DW];
               if (step == CW'(E_STB1)) stb[1] <= 1'b1;
               if (step == CW'(E_LOW))  xd     <= addr_q[AW-1-2*DW -: DW];
               if (step == CW'(E_STB0)) stb[0] <= 1'b1;
               if (step == CW'(E_DATA)) xd     <= data_q;
               if (step == CW'(E_SEL)) begin
                  if (mode_q) en          <= 1'b1;
                  else        cs_n[sel_q] <= 1'b0;
               end
               if (step == CW'(E_WR)) begin
                  wr    <= 1'b1;
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (bus_rdy) begin
                  wr    <= 1'b0;
                  en    <= 1'b0;
                  cs_n  <= '1;
                  done  <= 1'b1;
                  state <= ST_REL;
               end
            end
            default: begin
               done  <= 1'b0;
               stb   <= '0;
               xa    <= '0;
               xd    <= '0;
               state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/lwb_checker.sv
module lwb_checker #(
   parameter int DW  = 8,
   parameter int NCS = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [DW-1:0]  xd,
   input logic [2:0]     stb,
   input logic [NCS-1:0] cs_n,
   input logic           en,
   input logic           wr,
   input logic           done,
   input logic           err,
   input logic           bus_rdy
);
   AST_STB_ORDER_MID:   assert property (@(posedge clk) disable iff (!rst_n) $rose(stb[1]) |-> stb[2]); // R3
   AST_STB_ORDER_LOW:   assert property (@(posedge clk) disable iff (!rst_n) $rose(stb[0]) |-> stb[1]); // R3
   AST_XD_SETTLED:      assert property (@(posedge clk) disable iff (!rst_n) $rose(stb[0]) |-> $stable(xd)); // R3
   AST_MODE_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) en |-> (&cs_n)); // R5
   AST_ONE_SELECT:      assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R6
   AST_WR_QUALIFIED:    assert property (@(posedge clk) disable iff (!rst_n) wr |-> (en || !(&cs_n))); // R7
   AST_WR_HOLDS_WAIT:   assert property (@(posedge clk) disable iff (!rst_n) (wr && !bus_rdy) |=> wr); // R7
   AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
   AST_STB_TOGETHER:    assert property (@(posedge clk) disable iff (!rst_n)
                                         $fell(stb[2]) |-> ((stb == 3'b000) && (&cs_n) && !en)); // R8
   AST_ERR_QUIET:       assert property (@(posedge clk) disable iff (!rst_n) err |-> ((stb == 3'b000) && (&cs_n))); // R10
endmodule

bind lat_wr_seq lwb_checker #(.DW(DW), .NCS(NCS)) u_lwb_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .xd      (xd),
   .stb     (stb),
   .cs_n    (cs_n),
   .en      (en),
   .wr      (wr),
   .done    (done),
   .err     (err),
   .bus_rdy (bus_rdy)
);

// File: tb/tb_lat_wr_seq.sv
module tb_lat_wr_seq;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [27:0]  req_addr = '0;
   logic [7:0]   req_data = '0;
   logic         req_mode = 1'b0;
   logic [111:0] map_base;
   logic [111:0] map_mask;
   logic         bus_rdy = 1'b0;
   logic [11:0]  xa;
   logic [7:0]   xd;
   logic [2:0]   stb;
   logic [3:0]   cs_n;
   logic         en, wr, done, err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [27:0] wbase [4] = '{28'h1000000, 28'h2000000, 28'h5000000, 28'h0000000};
   logic [27:0] wmask [4] = '{28'hF000000, 28'hF000000, 28'hF000000, 28'h8000000};

   always #2 clk = ~clk;

   lat_wr_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .req_mode(req_mode), .map_base(map_base), .map_mask(map_mask),
      .bus_rdy(bus_rdy), .xa(xa), .xd(xd), .stb(stb), .cs_n(cs_n), .en(en), .wr(wr),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_sel(input logic [27:0] a);
      for (int i = 0; i < 4; i++)
         if (((a ^ wbase[i]) & wmask[i]) == 28'h0) return i;
      return -1;
   endfunction

   task automatic check_idle(input string req);
      chk(xa == 0 && xd == 0, req, "idle xa/xd", {12'h0, xa, xd}, 32'h0);
      chk(stb == 0 && cs_n == 4'hF, req, "idle stb/cs_n", {25'h0, stb, cs_n}, 32'hF);
      chk({en, wr, done, err} == 4'b0, req, "idle en/wr/done/err", {28'h0, en, wr, done, err}, 32'h0);
   endtask

   // one transfer; k indexes the edge just passed, sampled at the following falling edge
   task automatic xfer(input logic [27:0] a, input logic [7:0] d, input bit m,
                       input int w, input bit inject);
      int s;
      logic [7:0] exd;
      logic [2:0] estb;
      logic [3:0] ecs;
      bit act;
      s = exp_sel(a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d; req_mode = m; bus_rdy = 1'b0;
      for (int k = 0; k <= 17 + w; k++) begin
         @(negedge clk);
         if (k == 0) begin
            req_valid = 1'b0; req_addr = ~a; req_data = ~d; req_mode = ~m;
         end
         if (k < 4)            exd = a[27:20];
         else if (k < 8)       exd = a[19:12];
         else if (k < 12)      exd = a[11:4];
         else if (k < 16 + w)  exd = d;
         else                  exd = 8'h0;
         estb = {(k >= 2 && k < 16 + w), (k >= 6 && k < 16 + w), (k >= 10 && k < 16 + w)};
         act = (k >= 13 && k < 15 + w);
         ecs = (act && !m) ? ~(4'b1 << s) : 4'hF;
         chk(xa == ((k < 16 + w) ? a[11:0] : 12'h0), (k < 16 + w) ? "R2" : "R8",
             $sformatf("xa at E%0d", k), 32'(xa), 32'((k < 16 + w) ? a[11:0] : 12'h0));
         chk(xd == exd, (k < 4) ? "R2" : (k < 12) ? "R3" : (k < 16 + w) ? "R4" : "R8",
             $sformatf("xd at E%0d", k), 32'(xd), 32'(exd));
         chk(stb == estb, (k < 16 + w) ? "R3" : "R8", $sformatf("stb at E%0d", k), 32'(stb), 32'(estb));
         chk(cs_n == ecs, "R5/R6", $sformatf("cs_n at E%0d", k), 32'(cs_n), 32'(ecs));
         chk(en == (act && m), "R5", $sformatf("en at E%0d", k), 32'(en), 32'(act && m));
         chk(wr == (k >= 14 && k < 15 + w), "R7", $sformatf("wr at E%0d", k), 32'(wr),
             32'(k >= 14 && k < 15 + w));
         chk(done == (k == 15 + w), "R7", $sformatf("done at E%0d", k), 32'(done), 32'(k == 15 + w));
         chk(err == 1'b0, "R10", $sformatf("err at E%0d", k), 32'(err), 32'h0);
         if (inject && k == 4) begin
            req_valid = 1'b1; req_addr = 28'h2ABCDEF;  // R9: must be ignored
         end
         if (inject && k == 5) req_valid = 1'b0;
         bus_rdy = (k + 1 >= 15 + w);
      end
      bus_rdy = 1'b0;
      if (inject) begin
         @(negedge clk);
         check_idle("R9");
      end
   endtask

   task automatic unmapped(input logic [27:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(err == 1'b1, "R10", "err after unmapped request", 32'(err), 32'h1);
      chk(stb == 0 && cs_n == 4'hF && !en, "R10", "no bus activity", {27'h0, en, cs_n}, 32'hF);
      @(negedge clk);
      chk(err == 1'b0, "R10", "err pulse length", 32'(err), 32'h0);
      repeat (4) begin
         @(negedge clk);
         chk(stb == 0 && cs_n == 4'hF && xd == 0, "R10", "still idle", {21'h0, stb, xd}, 32'h0);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < 4; i++) begin
         map_base[i*28 +: 28] = wbase[i];
         map_mask[i*28 +: 28] = wmask[i];
      end
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      // directed corner cases: both modes, zero and nonzero waits, window priority (R6)
      xfer(28'h1A5C3E7, 8'h3C, 1'b0, 0, 1'b0);   // window 0 beats window 3
      xfer(28'h2123456, 8'hA5, 1'b1, 0, 1'b0);   // window 1, enable mode
      xfer(28'h5F0F0F0, 8'h81, 1'b0, 3, 1'b0);   // window 2, three waits
      xfer(28'h0777777, 8'h18, 1'b1, 4, 1'b0);   // window 3 only
      xfer(28'h3FEDCBA, 8'h42, 1'b0, 2, 1'b1);   // R9 mid-transfer pulse
      unmapped(28'h9000001);
      unmapped(28'hF123456);
      for (int n = 0; n < 20; n++) begin
         logic [27:0] a;
         a = {4'($urandom % 6), 24'($urandom)};
         xfer(a, 8'($urandom), 1'($urandom), int'($urandom % 6), 1'b0);
      end
      check_idle("R1");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule